// File: doc/BRIEF.md
# Bus Cycle Sequencer with Wait States

This block is the processor-side engine that turns a single transfer request into a timed external bus cycle. It steps through four time states per transfer (T1 to T4). Wait states can be stretched in after T3 for as long as the addressed device holds its ready line low. The block drives the strobes that external memory and I/O decoding rely on: address latch enable, read, write, data enable, transfer direction and the memory/I/O select.

Between transfers the sequencer sits in idle states. A requester presents one transfer at a time with a valid/accept handshake. A new transfer is taken only from idle or in the final state of the running cycle, so cycles can run back to back without a gap. An external bus master may ask for the bus with a hold input. The request is honoured only at a cycle boundary. The block then releases every bus output, signalled by a low output-enable, and raises its hold acknowledge until the hold input drops.

Top module: `bus_cycle_seq`

## Requirements
- R1: After T1 the sequencer always moves to T2 and then to T3. The state is visible on `tstate` with codes 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4, 6 hold.
- R2: `ready` is sampled only at the end of T3 and of each wait state. Low inserts a further wait state (code 4) and high moves to T4. A value of `ready` in any other state has no effect.
- R3: A transfer occupies exactly 4 + N clocks from T1 to T4 inclusive, where N is the number of sampled low `ready` values.
- R4: With no request and no hold the block stays in idle. In idle, `ale`, `rd_strobe`, `wr_strobe`, `den`, `dt_tx`, `mem_sel`, `data_oe` and `hlda` are 0, `addr_out` and `data_out` are 0, and `bus_oe` is 1.
- R5: `hold` is acted on only in idle or T4, and it takes priority over a pending request. The next state is hold, where `hlda`=1, `bus_oe`=0 and every strobe is 0. When `hold` drops, the next state is idle.
- R6: `ale` is 1 exactly in T1. `addr_out` carries the captured address from T1 through T4 and is 0 otherwise.
- R7: For a read, `rd_strobe` is 1 in T2, T3 and every wait state, and 0 in T1 and T4. For a write, `wr_strobe` behaves the same way. The two are never 1 together.
- R8: `den` is 1 over the same window as the strobes for both directions. For writes, `dt_tx` is 1 from T1 through T4. `data_oe` is 1 and `data_out` carries the write data from T2 through T4 of a write. In all other cases these are 0.
- R9: `req_accept` equals `req_valid` while in idle or T4 with `hold` low, and is 0 in every other state. An accepted request starts T1 on the next clock.
- R10: For an I/O transfer (`req_io`=1), `mem_sel` stays 0 and bits 19..16 of `addr_out` are 0. For a memory transfer, `mem_sel` is 1 from T1 through T4.
- R11: For a read, `data_in` is captured at the clock edge where `ready` is sampled high. It is shown on `rdata` with `rdata_valid`=1 during T4 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_accept | output | 1 | Request taken this clock |
| ready | input | 1 | Device ready; low stretches the cycle |
| hold | input | 1 | External master asks for the bus |
| data_in | input | 16 | Read data from the bus |
| tstate | output | 3 | Current time state code |
| ale | output | 1 | Address latch enable |
| addr_out | output | 20 | Bus address |
| mem_sel | output | 1 | 1 = memory cycle in progress |
| dt_tx | output | 1 | Direction: 1 = transmit |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| den | output | 1 | Data buffer enable |
| data_out | output | 16 | Write data on the bus |
| data_oe | output | 1 | Write data driven |
| rdata | output | 16 | Captured read data |
| rdata_valid | output | 1 | `rdata` is fresh (T4 of a read) |
| bus_oe | output | 1 | Bus outputs driven; 0 = floated |
| hlda | output | 1 | Hold acknowledge |

## Verification
The bench raises `hold` in the middle of a transfer. A sequencer that grants hold at once would cut T3 short and float the strobes while a device is mid-transfer. It also holds `req_valid` high while `hold` is high, and a design without hold priority would start a cycle the other master believes it owns. Runs of low `ready` of different lengths, plus `ready` pulsed high outside T3, show whether the stretch lands in the right place and whether a stray ready cuts a cycle short. Back-to-back requests accepted in T4, and I/O addresses with high bits set, expose an off-by-one gap and missing address masking.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_TW   = 3'd4,
    TS_T4   = 3'd5,
    TS_HOLD = 3'd6
  } tstate_e;

  // state that owns the bus for a transfer (T1..T4)
  function automatic logic in_transfer(tstate_e s);
    return (s == TS_T1) || (s == TS_T2) || (s == TS_T3) ||
           (s == TS_TW) || (s == TS_T4);
  endfunction

  // strobe window: T2, T3 and wait states
  function automatic logic in_strobe(tstate_e s);
    return (s == TS_T2) || (s == TS_T3) || (s == TS_TW);
  endfunction

  // points where a new request or a hold may be taken
  function automatic logic at_boundary(tstate_e s);
    return (s == TS_IDLE) || (s == TS_T4);
  endfunction

  // states in which READY is looked at
  function automatic logic ready_window(tstate_e s);
    return (s == TS_T3) || (s == TS_TW);
  endfunction

endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    hold,
  input  logic    ready,
  output tstate_e state,
  output logic    take,
  output logic    ready_hit,
  output logic    boundary
);

  tstate_e nxt;

  always_comb begin
    nxt       = state;
    take      = 1'b0;
    ready_hit = 1'b0;
    boundary  = at_boundary(state);
    unique case (state)
      TS_IDLE, TS_T4: begin
        if (hold) begin
          nxt = TS_HOLD;
        end else if (req_valid) begin
          take = 1'b1;
          nxt  = TS_T1;
        end else begin
          nxt = TS_IDLE;
        end
      end
      TS_T1: nxt = TS_T2;
      TS_T2: nxt = TS_T3;
      TS_T3, TS_TW: begin
        if (ready) begin
          ready_hit = 1'b1;
          nxt       = TS_T4;
        end else begin
          nxt = TS_TW;
        end
      end
      TS_HOLD: nxt = hold ? TS_HOLD : TS_IDLE;
      default: nxt = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= TS_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/bcs_req_reg.sv
module bcs_req_reg #(
  parameter int ADDR_W    = 20,
  parameter int IO_ADDR_W = 16,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              cur_write,
  output logic              cur_io,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata
);

  logic [ADDR_W-1:0] addr_eff;

  generate
    if (IO_ADDR_W < ADDR_W) begin : g_io_mask
      localparam int HI_W = ADDR_W - IO_ADDR_W;
      assign addr_eff = req_io ? {{HI_W{1'b0}}, req_addr[IO_ADDR_W-1:0]} : req_addr;
    end else begin : g_no_mask
      assign addr_eff = req_addr;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_write <= 1'b0;
      cur_io    <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else if (take) begin
      cur_write <= req_write;
      cur_io    <= req_io;
      cur_addr  <= addr_eff;
      cur_wdata <= req_wdata;
    end
  end

endmodule

// File: rtl/bcs_rdata_cap.sv
module bcs_rdata_cap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready_hit,
  input  logic              is_write,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rdata <= '0;
    else if (ready_hit && !is_write) rdata <= data_in;
  end

endmodule

// File: rtl/bcs_decode.sv
module bcs_decode
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  tstate_e           state,
  input  logic              cur_write,
  input  logic              cur_io,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  output logic              ale,
  output logic [ADDR_W-1:0] addr_out,
  output logic              mem_sel,
  output logic              dt_tx,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic              den,
  output logic              data_oe,
  output logic [DATA_W-1:0] data_out,
  output logic              rdata_valid,
  output logic              bus_oe,
  output logic              hlda
);

  logic act, win, wdrive;

  always_comb begin
    act    = in_transfer(state);
    win    = in_strobe(state);
    wdrive = cur_write && (win || state == TS_T4);

    ale         = (state == TS_T1);
    addr_out    = act ? cur_addr : '0;
    mem_sel     = act && !cur_io;
    dt_tx       = act && cur_write;
    rd_strobe   = win && !cur_write;
    wr_strobe   = win && cur_write;
    den         = win;
    data_oe     = wdrive;
    data_out    = wdrive ? cur_wdata : '0;
    rdata_valid = (state == TS_T4) && !cur_write;
    hlda        = (state == TS_HOLD);
    bus_oe      = (state != TS_HOLD);
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int IO_ADDR_W = 16,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_accept,
  input  logic              ready,
  input  logic              hold,
  input  logic [DATA_W-1:0] data_in,
  output logic [2:0]        tstate,
  output logic              ale,
  output logic [ADDR_W-1:0] addr_out,
  output logic              mem_sel,
  output logic              dt_tx,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic              den,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid,
  output logic              bus_oe,
  output logic              hlda
);

  tstate_e           state;
  logic              ev_ready_hit;
  logic              ev_boundary;
  logic              take;
  logic              cur_write, cur_io;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;

  bcs_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .hold      (hold),
    .ready     (ready),
    .state     (state),
    .take      (take),
    .ready_hit (ev_ready_hit),
    .boundary  (ev_boundary)
  );

  bcs_req_reg #(.ADDR_W(ADDR_W), .IO_ADDR_W(IO_ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .req_write (req_write),
    .req_io    (req_io),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cur_write (cur_write),
    .cur_io    (cur_io),
    .cur_addr  (cur_addr),
    .cur_wdata (cur_wdata)
  );

  bcs_rdata_cap #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready_hit (ev_ready_hit),
    .is_write  (cur_write),
    .data_in   (data_in),
    .rdata     (rdata)
  );

  bcs_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .state       (state),
    .cur_write   (cur_write),
    .cur_io      (cur_io),
    .cur_addr    (cur_addr),
    .cur_wdata   (cur_wdata),
    .ale         (ale),
    .addr_out    (addr_out),
    .mem_sel     (mem_sel),
    .dt_tx       (dt_tx),
    .rd_strobe   (rd_strobe),
    .wr_strobe   (wr_strobe),
    .den         (den),
    .data_oe     (data_oe),
    .data_out    (data_out),
    .rdata_valid (rdata_valid),
    .bus_oe      (bus_oe),
    .hlda        (hlda)
  );

  assign req_accept = take;
  assign tstate     = state;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic       hold,
  input logic [2:0] tstate,
  input logic       ale,
  input logic       rd_strobe,
  input logic       wr_strobe,
  input logic       den,
  input logic       hlda,
  input logic       bus_oe,
  input logic       rdata_valid,
  input logic       req_accept,
  input logic       ev_ready_hit,
  input logic       ev_boundary
);

  assert_t1_to_t2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tstate == 3'd1 |=> tstate == 3'd2);

  assert_t2_to_t3_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tstate == 3'd2 |=> tstate == 3'd3);

  assert_wait_on_low_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate == 3'd3 || tstate == 3'd4) && !ready |=> tstate == 3'd4);

  assert_ready_hit_to_t4_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready_hit |=> tstate == 3'd5);

  assert_hold_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(ev_boundary) && $past(hold));

  assert_hold_floats_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !bus_oe && !rd_strobe && !wr_strobe && !ale && !den);

  assert_ale_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  assert_no_rd_wr_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe));

  assert_accept_only_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> ev_boundary && !hold);

  assert_rdata_in_t4_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> tstate == 3'd5);

endmodule

bind bus_cycle_seq bcs_checker u_bcs_checker (.*);

// File: tb/tb_bus_cycle_seq.sv
`timescale 1ns/1ps
module tb_bus_cycle_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        ready = 1'b0, hold = 1'b0;
  logic [15:0] data_in = '0;
  logic        req_accept;
  logic [2:0]  tstate;
  logic        ale, mem_sel, dt_tx, rd_strobe, wr_strobe, den, data_oe;
  logic        rdata_valid, bus_oe, hlda;
  logic [19:0] addr_out;
  logic [15:0] data_out, rdata;

  always #2 clk = ~clk;

  bus_cycle_seq dut (.*);

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // reference model: phase 0 idle, 1..3 T1..T3, 4 wait, 5 T4, 6 hold
  int          ph = 0;
  bit          m_w, m_io;
  logic [19:0] m_addr;
  logic [15:0] m_wd, m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0;
    end else begin
      if (ph == 0 || ph == 5) begin
        if (hold) ph = 6;
        else if (req_valid) begin
          m_w = req_write; m_io = req_io; m_wd = req_wdata;
          m_addr = req_io ? (req_addr & 20'h0FFFF) : req_addr;
          ph = 1;
        end else ph = 0;
      end else if (ph == 1 || ph == 2) ph = ph + 1;
      else if (ph == 3 || ph == 4) begin
        if (ready) begin
          if (!m_w) m_rd = data_in;
          ph = 5;
        end else ph = 4;
      end else if (ph == 6) begin
        if (!hold) ph = 0;
      end
    end
  end

  // ready driver and length bookkeeping
  int wq[$];
  int budget = 0;
  int wc = 0;
  int len = 0;
  bit stray_ready = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      bit act, win;
      act = (ph >= 1 && ph <= 5);
      win = (ph >= 2 && ph <= 4);
      chk("R1 tstate", tstate, ph);
      chk("R6 ale", ale, ph == 1);
      chk(m_io ? "R10 addr_out" : "R6 addr_out", addr_out, act ? m_addr : 20'h0);
      chk("R10 mem_sel", mem_sel, act && !m_io);
      chk("R7 rd_strobe", rd_strobe, win && !m_w);
      chk("R7 wr_strobe", wr_strobe, win && m_w);
      chk("R8 den", den, win);
      chk("R8 dt_tx", dt_tx, act && m_w);
      chk("R8 data_oe", data_oe, m_w && ph >= 2 && ph <= 5);
      chk("R8 data_out", data_out, (m_w && ph >= 2 && ph <= 5) ? m_wd : 16'h0);
      chk("R5 hlda", hlda, ph == 6);
      chk("R5 bus_oe", bus_oe, ph != 6);
      chk("R9 req_accept", req_accept, (ph == 0 || ph == 5) && !hold && req_valid);
      chk("R11 rdata_valid", rdata_valid, ph == 5 && !m_w);
      if (ph == 5 && !m_w) chk("R11 rdata", rdata, m_rd);
      if (ph == 0 && !req_valid && !hold) chk("R4 idle strobes", {ale, rd_strobe, wr_strobe, den}, 0);
    end
    if (tstate == 3'd1) begin
      len = 1;
      if (wq.size() > 0) budget = wq.pop_front();
    end else if (tstate >= 3'd2 && tstate <= 3'd5) len++;
    if (tstate == 3'd5 && rst_n) chk("R3 cycle length", len, 4 + budget);
    if (tstate == 3'd3) wc = 0;
    if (tstate == 3'd4) wc++;
    ready = (tstate == 3'd3 || tstate == 3'd4) ? (wc >= budget) : stray_ready;
    data_in = 16'h1000 + 16'(cyc * 7);
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic issue(input bit w, input bit io, input logic [19:0] a,
                       input logic [15:0] d, input int n);
    @(posedge clk); #1;
    wq.push_back(n);
    req_valid = 1'b1; req_write = w; req_io = io; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_accept);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    // R4: reset state
    repeat (2) @(negedge clk);
    chk("R4 reset tstate", tstate, 0);
    chk("R4 reset strobes", {ale, rd_strobe, wr_strobe, den, dt_tx, mem_sel, hlda}, 0);
    chk("R4 reset bus_oe", bus_oe, 1);
    @(posedge clk); #1 rst_n = 1'b1;
    idle(4);                                   // R4 idle hold-off
    issue(1'b0, 1'b0, 20'hA1234, 16'h0, 0);    // memory read, no wait
    issue(1'b1, 1'b0, 20'h50F0E, 16'hBEEF, 2); // R3: 4+2 clocks
    issue(1'b0, 1'b1, 20'hFABCD, 16'h0, 1);    // R10 I/O read, masked
    issue(1'b1, 1'b1, 20'h31234, 16'h55AA, 0); // R10 I/O write
    idle(3);
    // R9: back-to-back, accepted in T4
    issue(1'b0, 1'b0, 20'h00010, 16'h0, 0);
    issue(1'b1, 1'b0, 20'h00012, 16'h1111, 0);
    issue(1'b0, 1'b0, 20'h00014, 16'h0, 3);
    // R2: stray ready outside T3/wait is ignored
    stray_ready = 1'b1;
    issue(1'b0, 1'b0, 20'h7777F, 16'h0, 2);
    issue(1'b1, 1'b1, 20'h0ABCD, 16'h2222, 1);
    stray_ready = 1'b0;
    idle(2);
    // R5: hold in idle
    hold = 1'b1; idle(4); hold = 1'b0; idle(2);
    // R5: hold raised mid-cycle, granted after T4
    issue(1'b0, 1'b0, 20'h12345, 16'h0, 2);
    hold = 1'b1; idle(10);
    // R5: hold has priority over a pending request
    wq.push_back(1);
    req_valid = 1'b1; req_write = 1'b1; req_io = 1'b0; req_addr = 20'hCAFE0; req_wdata = 16'h3C3C;
    idle(3);
    hold = 1'b0;
    do @(negedge clk); while (!req_accept);
    @(posedge clk); #1 req_valid = 1'b0;
    idle(12);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule